// File: doc/BRIEF.md
# Prioritized Operand Bypass Selector

This combinational unit sits in the decode stage of a five-stage pipelined processor and produces the two operands that are loaded into the execute-stage pipeline register. For each operand it compares the decoded source register number with the destination register numbers of five in-flight results. Those results come from the execute, memory and write-back stages. When one or more of them match, the unit picks the youngest one. Otherwise it passes the value read from the register file.

Operand A has one extra duty. For call and jump instructions it carries the address of the next sequential instruction (the incremented PC) in place of a register value. This lets the downstream pipeline register hold one word fewer.

Register number 15 (all ones) means "no register". It never produces a bypass hit. The unit has no state. Stalling on load-use hazards, the register file and the pipeline registers are outside this block.

Top module: `opfwd_sel`

## Requirements
- R1: When no bypass source matches, opnd_a equals rf_a_data and opnd_b equals rf_b_data.
- R2: A match on ex_dst_e selects ex_alu_res over every other matching source.
- R3: When ex_dst_e does not match, a match on mem_dst_m selects mem_load_data over mem_dst_e and both write-back sources.
- R4: When neither execute nor memory-stage loaded data match, a match on mem_dst_e selects mem_alu_res over both write-back sources.
- R5: Among the write-back sources, a match on wb_dst_m (wb_load_data) wins over wb_dst_e (wb_alu_res). wb_alu_res is used only when it is the sole match.
- R6: Register number 4'hF never matches. A destination of 4'hF is never selected, and a source of 4'hF always yields the register-file value.
- R7: When dec_op is 4'h7 (jump) or 4'h8 (call), opnd_a equals dec_pc_next regardless of any bypass match.
- R8: opnd_b uses the same five-source priority as opnd_a and is never replaced by dec_pc_next, for any dec_op.
- R9: The A and B selections are independent. In the same cycle they may draw from different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode of the instruction in decode |
| dec_pc_next | input | 64 | Address of the next sequential instruction |
| src_a_id | input | 4 | Register number for operand A |
| src_b_id | input | 4 | Register number for operand B |
| rf_a_data | input | 64 | Register file read data, port A |
| rf_b_data | input | 64 | Register file read data, port B |
| ex_dst_e | input | 4 | Execute stage ALU destination |
| ex_alu_res | input | 64 | Execute stage ALU result |
| mem_dst_m | input | 4 | Memory stage load destination |
| mem_load_data | input | 64 | Memory stage loaded data |
| mem_dst_e | input | 4 | Memory stage ALU destination |
| mem_alu_res | input | 64 | Memory stage ALU result |
| wb_dst_m | input | 4 | Write-back stage load destination |
| wb_load_data | input | 64 | Write-back stage loaded data |
| wb_dst_e | input | 4 | Write-back stage ALU destination |
| wb_alu_res | input | 64 | Write-back stage ALU result |
| opnd_a | output | 64 | Selected operand A |
| opnd_b | output | 64 | Selected operand B |

## Verification
Two functions can act on operand A in the same cycle: the next-PC substitution for call and jump, and a bypass hit on the A source register. The bench provokes this by sweeping every destination pattern drawn from the A register, the B register and 4'hF, with the opcode set in turn to jump, call and a plain opcode. It expects dec_pc_next on A whenever the opcode is jump or call, while B still follows the priority order.

The second collision is several stages naming the same register at once. In the same sweep, each result is judged against an arithmetic priority model that picks the lowest-numbered matching stage.

// File: rtl/opfwd_pkg.sv
// Shared widths, register and opcode encodings for the operand bypass selector.
// Assumes a 16-entry register namespace in which the all-ones number means "no register".
package opfwd_pkg;
    localparam int unsigned DATA_W  = 64;
    localparam int unsigned REG_W   = 4;
    localparam int unsigned OP_W    = 4;
    localparam int unsigned NUM_SRC = 5;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [REG_W-1:0]  rid_t;
    typedef logic [OP_W-1:0]   op_t;

    localparam rid_t REG_NONE = '1;
    localparam op_t  OP_JUMP  = op_t'(7);
    localparam op_t  OP_CALL  = op_t'(8);
endpackage

// File: rtl/fwd_id_match.sv
// Compares one wanted register number with one in-flight destination.
// Assumes REG_NONE never names a real register, so it is excluded from matching.
module fwd_id_match
    import opfwd_pkg::*;
(
    input  rid_t want_id,
    input  rid_t dst_id,
    output logic hit
);
    // Hit only for a real destination equal to the wanted register.
    assign hit = (dst_id != REG_NONE) && (dst_id == want_id);
endmodule

// File: rtl/fwd_prio_mux.sv
// Selects the youngest matching bypass value for one operand, else the register file value.
// Assumes entry 0 of the source arrays is the youngest and the last entry is the oldest.
module fwd_prio_mux
    import opfwd_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
)(
    input  rid_t  want_id,
    input  word_t rf_data,
    input  rid_t  dst_ids  [N_SRC],
    input  word_t dst_vals [N_SRC],
    output word_t result
);
    logic [N_SRC-1:0] hits;

    // One comparator per bypass source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_match
        fwd_id_match u_match (
            .want_id (want_id),
            .dst_id  (dst_ids[g]),
            .hit     (hits[g])
        );
    end

    // Walk from oldest to youngest so the youngest hit is written last and wins.
    always_comb begin
        result = rf_data;
        for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
            if (hits[i]) begin
                result = dst_vals[i];
            end
        end
    end
endmodule

// File: rtl/link_merge.sv
// Substitutes the next-PC word for the bypassed A operand on jump and call.
// Assumes the opcode encodings of opfwd_pkg.
module link_merge
    import opfwd_pkg::*;
(
    input  op_t   dec_op,
    input  word_t pc_next,
    input  word_t fwd_val,
    output word_t merged
);
    logic use_pc;

    // Jump and call carry the next-PC word in operand A.
    assign use_pc = (dec_op == OP_JUMP) || (dec_op == OP_CALL);

    // The next-PC word takes precedence over any bypass result.
    assign merged = use_pc ? pc_next : fwd_val;
endmodule

// File: rtl/opfwd_sel.sv
// Decode-stage operand selector: five-source youngest-first bypass for A and B,
// with next-PC substitution on A for jump and call. Purely combinational.
// Assumes the stage results are presented with their destination numbers, REG_NONE when unused.
module opfwd_sel
    import opfwd_pkg::*;
(
    input  logic [3:0]  dec_op,
    input  logic [63:0] dec_pc_next,
    input  logic [3:0]  src_a_id,
    input  logic [3:0]  src_b_id,
    input  logic [63:0] rf_a_data,
    input  logic [63:0] rf_b_data,
    input  logic [3:0]  ex_dst_e,
    input  logic [63:0] ex_alu_res,
    input  logic [3:0]  mem_dst_m,
    input  logic [63:0] mem_load_data,
    input  logic [3:0]  mem_dst_e,
    input  logic [63:0] mem_alu_res,
    input  logic [3:0]  wb_dst_m,
    input  logic [63:0] wb_load_data,
    input  logic [3:0]  wb_dst_e,
    input  logic [63:0] wb_alu_res,
    output logic [63:0] opnd_a,
    output logic [63:0] opnd_b
);
    rid_t  dst_ids  [NUM_SRC];
    word_t dst_vals [NUM_SRC];
    word_t a_fwd;

    // Pack the sources youngest first; index order is the priority order.
    always_comb begin
        dst_ids[0] = ex_dst_e;   dst_vals[0] = ex_alu_res;
        dst_ids[1] = mem_dst_m;  dst_vals[1] = mem_load_data;
        dst_ids[2] = mem_dst_e;  dst_vals[2] = mem_alu_res;
        dst_ids[3] = wb_dst_m;   dst_vals[3] = wb_load_data;
        dst_ids[4] = wb_dst_e;   dst_vals[4] = wb_alu_res;
    end

    fwd_prio_mux #(.N_SRC(NUM_SRC)) u_mux_a (
        .want_id  (src_a_id),
        .rf_data  (rf_a_data),
        .dst_ids  (dst_ids),
        .dst_vals (dst_vals),
        .result   (a_fwd)
    );

    fwd_prio_mux #(.N_SRC(NUM_SRC)) u_mux_b (
        .want_id  (src_b_id),
        .rf_data  (rf_b_data),
        .dst_ids  (dst_ids),
        .dst_vals (dst_vals),
        .result   (opnd_b)
    );

    link_merge u_merge (
        .dec_op  (dec_op),
        .pc_next (dec_pc_next),
        .fwd_val (a_fwd),
        .merged  (opnd_a)
    );
endmodule

// File: rtl/opfwd_sel_chk.sv
// Immediate-assertion checker for opfwd_sel, bound to every instance.
// Assumes combinational settling before the checker block evaluates.
module opfwd_sel_chk (
    input logic [3:0]  dec_op,
    input logic [63:0] dec_pc_next,
    input logic [3:0]  src_a_id,
    input logic [3:0]  src_b_id,
    input logic [63:0] rf_a_data,
    input logic [63:0] rf_b_data,
    input logic [3:0]  ex_dst_e,
    input logic [63:0] ex_alu_res,
    input logic [3:0]  mem_dst_m,
    input logic [63:0] mem_load_data,
    input logic [3:0]  mem_dst_e,
    input logic [63:0] mem_alu_res,
    input logic [3:0]  wb_dst_m,
    input logic [63:0] wb_load_data,
    input logic [3:0]  wb_dst_e,
    input logic [63:0] wb_alu_res,
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b
);
    logic link;
    logic a_any, b_any;
    logic a_ex, a_mm, b_ex;

    // Port-level view of which stages name each source register.
    always_comb begin
        link  = (dec_op == 4'h7) || (dec_op == 4'h8);
        a_ex  = (ex_dst_e  == src_a_id) && (src_a_id != 4'hF);
        a_mm  = (mem_dst_m == src_a_id) && (src_a_id != 4'hF);
        b_ex  = (ex_dst_e  == src_b_id) && (src_b_id != 4'hF);
        a_any = (src_a_id != 4'hF) &&
                ((ex_dst_e == src_a_id) || (mem_dst_m == src_a_id) || (mem_dst_e == src_a_id) ||
                 (wb_dst_m == src_a_id) || (wb_dst_e == src_a_id));
        b_any = (src_b_id != 4'hF) &&
                ((ex_dst_e == src_b_id) || (mem_dst_m == src_b_id) || (mem_dst_e == src_b_id) ||
                 (wb_dst_m == src_b_id) || (wb_dst_e == src_b_id));
    end

    // Relate outputs to the stage inputs that should have produced them.
    always_comb begin
        if (!link && !a_any) assert_a_regfile_R1: assert (opnd_a == rf_a_data);
        if (!b_any)          assert_b_regfile_R1: assert (opnd_b == rf_b_data);
        if (!link && a_ex)   assert_a_exec_first_R2: assert (opnd_a == ex_alu_res);
        if (!link && !a_ex && a_mm) assert_a_mem_load_R3: assert (opnd_a == mem_load_data);
        if (src_b_id == 4'hF) assert_none_id_R6: assert (opnd_b == rf_b_data);
        if (link)            assert_link_pc_R7: assert (opnd_a == dec_pc_next);
        if (b_ex)            assert_b_exec_first_R8: assert (opnd_b == ex_alu_res);
    end
endmodule

bind opfwd_sel opfwd_sel_chk u_chk (.*);

// File: tb/opfwd_sel_tb.sv
module opfwd_sel_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]  op, sa, sb;
    logic [63:0] pcn, rfa, rfb;
    logic [3:0]  d [5];
    logic [63:0] v [5];
    logic [63:0] oa, ob;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    opfwd_sel u_dut (
        .dec_op(op), .dec_pc_next(pcn), .src_a_id(sa), .src_b_id(sb),
        .rf_a_data(rfa), .rf_b_data(rfb),
        .ex_dst_e(d[0]),  .ex_alu_res(v[0]),
        .mem_dst_m(d[1]), .mem_load_data(v[1]),
        .mem_dst_e(d[2]), .mem_alu_res(v[2]),
        .wb_dst_m(d[3]),  .wb_load_data(v[3]),
        .wb_dst_e(d[4]),  .wb_alu_res(v[4]),
        .opnd_a(oa), .opnd_b(ob)
    );

    // Reference: first (youngest) real destination equal to the wanted register.
    function automatic logic [63:0] pick(input logic [3:0] want, input logic [63:0] rf,
                                         output int win);
        logic [63:0] r = rf;
        win = -1;
        for (int i = 4; i >= 0; i--)
            if (d[i] != 4'hF && d[i] == want) begin r = v[i]; win = i; end
        return r;
    endfunction

    function automatic string tag_of(input int win);
        case (win)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        for (int i = 0; i < 5; i++) begin
            d[i] = 4'hF;
            v[i] = {8'hC0 + 8'(i), 56'h00_1234_5678_9A00} + 64'(i);
        end
        op = 4'h6; sa = 4'h3; sb = 4'h5;
        rfa = 64'h1111_2222_3333_4444; rfb = 64'h5555_6666_7777_8888;
        pcn = 64'h0000_0000_0040_0A0A;
    endtask

    task automatic judge();
        int wa, wb;
        logic [63:0] ea, eb;
        logic lnk;
        #2;
        lnk = (op == 4'h7) || (op == 4'h8);
        ea = pick(sa, rfa, wa);
        eb = pick(sb, rfb, wb);
        if (lnk) chk("R7 A next-pc", oa, pcn);
        else     chk({tag_of(wa), " A"}, oa, ea);
        chk({"R8 ", tag_of(wb), " B"}, ob, eb);
        #2;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        set_idle();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle pattern: everything comes from the register file (R1).
        #2; chk("R1 idle A", oa, rfa); chk("R1 idle B", ob, rfb); #2;

        // Directed: all five name register 3; the execute source wins (R2).
        for (int i = 0; i < 5; i++) d[i] = 4'h3;
        #2; chk("R2 all match", oa, v[0]); chk("R1 B untouched", ob, rfb); #2;
        d[0] = 4'hF;
        #2; chk("R3 mem load over rest", oa, v[1]); #2;
        d[1] = 4'hF;
        #2; chk("R4 mem alu over wb", oa, v[2]); #2;
        d[2] = 4'hF;
        #2; chk("R5 wb load over wb alu", oa, v[3]); #2;
        d[3] = 4'hF;
        #2; chk("R5 wb alu alone", oa, v[4]); #2;

        // Register 15 on both sides never matches (R6).
        set_idle(); sb = 4'hF; for (int i = 0; i < 5; i++) d[i] = 4'hF;
        #2; chk("R6 none id B", ob, rfb); #2;

        // Jump and call replace A even with an execute hit (R7); B keeps bypass (R8).
        set_idle(); d[0] = 4'h3; d[2] = 4'h5; op = 4'h7;
        #2; chk("R7 jump", oa, pcn); chk("R8 B under jump", ob, v[2]); #2;
        op = 4'h8;
        #2; chk("R7 call", oa, pcn); chk("R8 B under call", ob, v[2]); #2;

        // Independent sources in one cycle (R9).
        set_idle(); d[1] = 4'h3; d[4] = 4'h5;
        #2; chk("R9 A mem", oa, v[1]); chk("R9 B wb", ob, v[4]); #2;

        // Sweep: each destination from {3,5,F}, sources from {3,5,F}, three opcodes.
        set_idle();
        for (int o = 0; o < 3; o++) begin
            for (int s = 0; s < 9; s++) begin
                for (int c = 0; c < 243; c++) begin
                    int k = c;
                    op = (o == 0) ? 4'h6 : ((o == 1) ? 4'h7 : 4'h8);
                    sa = (s % 3 == 0) ? 4'h3 : ((s % 3 == 1) ? 4'h5 : 4'hF);
                    sb = (s / 3 == 0) ? 4'h5 : ((s / 3 == 1) ? 4'h3 : 4'hF);
                    for (int i = 0; i < 5; i++) begin
                        d[i] = (k % 3 == 0) ? 4'h3 : ((k % 3 == 1) ? 4'h5 : 4'hF);
                        k = k / 3;
                    end
                    judge();
                end
            end
        end

        // Random spread over the full register range and opcodes.
        for (int n = 0; n < 600; n++) begin
            op = 4'($urandom_range(0, 15));
            sa = 4'($urandom_range(0, 15));
            sb = 4'($urandom_range(0, 15));
            rfa = {$urandom, $urandom}; rfb = {$urandom, $urandom}; pcn = {$urandom, $urandom};
            for (int i = 0; i < 5; i++) begin
                d[i] = 4'($urandom_range(0, 15));
                v[i] = {$urandom, $urandom};
            end
            judge();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule